// File: doc/BRIEF.md
# Decimation Period and Ready Strobe Generator

This block sets the output-sample timing of one decimating receiver channel. Software writes a stored decimation value (equal to N-1) and an output mode through a byte-wide register port. From these the block derives the length of each output sample period: 2N, 4N or 8N input samples. A down-counter advances on every clock where the sample-enable input is high. Each time it wraps, a new period begins and a ready strobe pulses.

The strobe can be set active-high or active-low, and its pulse can last 4 or 16 clocks. A change to the decimation value or to the output mode is picked up at the next period boundary, so a period already running always completes at its original length. The downstream filter datapath uses the strobe to know when a fresh output sample is due.

Top module: `decim_strobe_gen`

## Requirements
- R1: Address 1 holds the low 8 bits of the 14-bit stored value. Address 2 bits 5:0 hold its upper 6 bits, and bits 7:6 of address 2 always read zero. Address 3 reads zero.
- R2: After reset, address 0 reads 0x00, address 1 reads 0x07 and address 2 reads 0x00, and the strobe output is low.
- R3: The mode byte at address 0 has these fields: bit 0 selects real output, bit 1 selects the extra divide, bit 2 inverts the strobe and bit 3 selects the long pulse. Its bits 7:4 always read zero.
- R4: With bit 0 of the mode byte set, the period is 2N enabled samples, whatever the value of bit 1.
- R5: With bit 0 clear, the period is 4N enabled samples, or 8N when bit 1 is set.
- R6: The first enabled cycle after reset starts a period. Every period start is followed by a strobe that is active for 4 clocks, or for 16 clocks when bit 3 is set.
- R7: With bit 2 set, the strobe idles high and pulses low. The polarity follows the bit at once.
- R8: The period counter advances only on cycles where sample_en is high. The strobe width is counted in clocks.
- R9: A write to a decimation byte or to mode bits 0 and 1 leaves the period in progress unchanged and takes effect from the next period.
- R10: When the period is shorter than the strobe width, the pulse restarts at each period start, so the strobe stays active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address for read and write |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the addressed register (combinational) |
| sample_en | input | 1 | Input sample valid; advances the period counter |
| ready_o | output | 1 | Ready strobe at each output period start |

## Verification
The hardest case to reach is a configuration write that lands in the middle of a running period. A faulty design would cut that period short, and the fault shows only in the spacing between two particular strobes. The bench synchronises to a strobe edge and writes a new value a few cycles later. It then measures the interrupted period, which must keep its old length, and the following period, which must have the new length. It does this once for a decimation byte and once for the output mode. Clipping is reached by writing stored values below the specified minimum, so that the period becomes shorter than the pulse.

// File: rtl/decim_strobe_gen.sv
module decim_strobe_gen #(
  parameter int DEC_W       = 14,
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 2,
  parameter int SHORT_PULSE = 4,
  parameter int LONG_PULSE  = 16,
  parameter logic [DEC_W-1:0] DEC_RESET = 14'd7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              sample_en,
  output logic              ready_o
);
  localparam int HI_W  = DEC_W - DATA_W;
  localparam int CNT_W = DEC_W + 4;
  localparam int PW_W  = $clog2(LONG_PULSE + 1);

  logic [DEC_W-1:0] dec_q;
  logic             real_q, x8_q, inv_q, wide_q;
  logic [CNT_W-1:0] cnt_q, n_ext, period, reload;
  logic [PW_W-1:0]  left_q;
  logic             boundary;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_q  <= DEC_RESET;
      real_q <= 1'b0;
      x8_q   <= 1'b0;
      inv_q  <= 1'b0;
      wide_q <= 1'b0;
    end else if (wr_en) begin
      case (addr)
        ADDR_W'(0): {wide_q, inv_q, x8_q, real_q} <= wr_data[3:0];
        ADDR_W'(1): dec_q[DATA_W-1:0] <= wr_data;
        ADDR_W'(2): dec_q[DEC_W-1:DATA_W] <= wr_data[HI_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      ADDR_W'(0): rd_data = {{(DATA_W-4){1'b0}}, wide_q, inv_q, x8_q, real_q};
      ADDR_W'(1): rd_data = dec_q[DATA_W-1:0];
      ADDR_W'(2): rd_data = {{(DATA_W-HI_W){1'b0}}, dec_q[DEC_W-1:DATA_W]};
      default:    rd_data = '0;
    endcase
  end

  assign n_ext    = {4'b0000, dec_q} + CNT_W'(1);
  assign period   = real_q ? (n_ext << 1) : (x8_q ? (n_ext << 3) : (n_ext << 2));
  assign reload   = period - CNT_W'(1);
  assign boundary = sample_en && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      left_q <= '0;
    end else if (boundary) begin
      cnt_q  <= reload;
      left_q <= wide_q ? PW_W'(LONG_PULSE) : PW_W'(SHORT_PULSE);
    end else begin
      if (sample_en) cnt_q <= cnt_q - CNT_W'(1);
      if (left_q != '0) left_q <= left_q - PW_W'(1);
    end
  end

  assign ready_o = (left_q != '0) ^ inv_q;
endmodule

module decim_strobe_gen_chk #(
  parameter int DATA_W     = 8,
  parameter int ADDR_W     = 2,
  parameter int HI_W       = 6,
  parameter int CNT_W      = 18,
  parameter int PW_W       = 5,
  parameter int LONG_PULSE = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] rd_data,
  input logic              sample_en,
  input logic              ready_o,
  input logic              inv_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [PW_W-1:0]   left_q
);
  a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADDR_W'(2)) |-> (rd_data[DATA_W-1:HI_W] == '0));

  a_r3_mode_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADDR_W'(0)) |-> (rd_data[DATA_W-1:4] == '0));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_en |=> $stable(cnt_q));

  a_r6_start: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && cnt_q == '0) |=> (ready_o ^ inv_q));

  a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (!(sample_en && cnt_q == '0) && left_q == '0) |=> (left_q == '0));

  a_r6_width_cap: assert property (@(posedge clk) disable iff (!rst_n)
    left_q <= PW_W'(LONG_PULSE));
endmodule

bind decim_strobe_gen decim_strobe_gen_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .HI_W(HI_W), .CNT_W(CNT_W),
  .PW_W(PW_W), .LONG_PULSE(LONG_PULSE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .rd_data(rd_data),
  .sample_en(sample_en), .ready_o(ready_o), .inv_q(inv_q),
  .cnt_q(cnt_q), .left_q(left_q)
);

// File: tb/decim_strobe_gen_test.sv
module decim_strobe_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] rd_data;
  logic       sample_en;
  logic       ready_o;
  logic       en_on = 1'b0, en_toggle = 1'b0, phase = 1'b0;
  logic       inv_b = 1'b0;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;
  always @(negedge clk) phase <= ~phase;
  assign sample_en = en_on && (!en_toggle || phase);

  decim_strobe_gen uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .sample_en(sample_en), .ready_o(ready_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int d);
    @(negedge clk);
    addr = a;
    #1 d = rd_data;
  endtask

  function automatic logic active();
    return ready_o ^ inv_b;
  endfunction

  task automatic wait_rise(input string req);
    logic prev = active();
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (active() && !prev) return;
      prev = active();
    end
    check(req, 0, 1);
  endtask

  task automatic count_to_rise(input int wr_at, input logic [1:0] a, input logic [7:0] d,
                               output int n, output int w);
    logic prev = 1'b1;
    n = 0; w = 1;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (i == wr_at) begin wr_en = 1'b1; addr = a; wr_data = d; end
      else wr_en = 1'b0;
      n++;
      if (active() && !prev) return;
      if (active()) w++;
      prev = active();
    end
    n = -1;
  endtask

  task automatic measure(input string req, output int p, output int w);
    int dn, dw;
    wait_rise(req);
    count_to_rise(-1, 2'd0, 8'd0, dn, dw);
    count_to_rise(-1, 2'd0, 8'd0, p, w);
  endtask

  task automatic t_reset();
    int d;
    rd(2'd0, d); check("R2 mode reset", d, 8'h00);
    rd(2'd1, d); check("R2 low reset", d, 8'h07);
    rd(2'd2, d); check("R2 upper reset", d, 8'h00);
    check("R2 strobe low", int'(ready_o), 0);
  endtask

  task automatic t_default();
    int p, w;
    en_on = 1'b1;
    measure("R6", p, w);
    check("R5 complex period 4N", p, 32);
    check("R6 short width", w, 4);
  endtask

  task automatic t_modes();
    int p, w;
    wr(2'd0, 8'h01); measure("R4", p, w); check("R4 real period 2N", p, 16);
    wr(2'd0, 8'h03); measure("R4", p, w); check("R4 real ignores divide bit", p, 16);
    wr(2'd0, 8'h02); measure("R5", p, w); check("R5 extra divide 8N", p, 64);
    wr(2'd0, 8'h08); measure("R6", p, w);
    check("R6 long period", p, 32); check("R6 long width", w, 16);
  endtask

  task automatic t_polarity();
    int p, w;
    wr(2'd0, 8'h04); inv_b = 1'b1;
    measure("R7", p, w);
    check("R7 inverted period", p, 32); check("R7 inverted width", w, 4);
    repeat (10) @(negedge clk);
    check("R7 idle high", int'(ready_o), 1);
    wr(2'd0, 8'h00); inv_b = 1'b0;
    #1 check("R7 polarity immediate", int'(ready_o), 0);
  endtask

  task automatic t_regs();
    int d;
    wr(2'd2, 8'hFF); rd(2'd2, d); check("R1 upper bits 7:6 zero", d, 8'h3F);
    wr(2'd0, 8'hFF); rd(2'd0, d); check("R3 mode bits 7:4 zero", d, 8'h0F);
    rd(2'd3, d); check("R1 address 3 zero", d, 0);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_large();
    int p, w, d;
    wr(2'd1, 8'h03); wr(2'd2, 8'h01);
    rd(2'd1, d); check("R1 low byte", d, 8'h03);
    measure("R1", p, w); check("R1 14-bit value period", p, 1040);
    wr(2'd2, 8'h00); wr(2'd1, 8'h07);
  endtask

  task automatic t_midwrite();
    int p, w;
    measure("R9", p, w); check("R9 steady", p, 32);
    count_to_rise(5, 2'd1, 8'd15, p, w); check("R9 period kept after value write", p, 32);
    count_to_rise(-1, 2'd0, 8'd0, p, w); check("R9 new value next period", p, 64);
    count_to_rise(5, 2'd0, 8'h01, p, w); check("R9 period kept after mode write", p, 64);
    count_to_rise(-1, 2'd0, 8'd0, p, w); check("R9 new mode next period", p, 32);
    wr(2'd0, 8'h00); wr(2'd1, 8'h07);
  endtask

  task automatic t_gating();
    int p, w;
    en_toggle = 1'b1;
    measure("R8", p, w);
    check("R8 half-rate period in clocks", p, 64);
    check("R8 width in clocks", w, 4);
    en_on = 1'b0; repeat (40) @(negedge clk);
    check("R8 no strobe without enable", int'(ready_o), 0);
    en_toggle = 1'b0; en_on = 1'b1;
  endtask

  task automatic t_clip();
    int p, w, on;
    wr(2'd1, 8'h02); wr(2'd0, 8'h01);
    measure("R10", p, w); check("R10 short period", p, 6); check("R10 short width", w, 4);
    wr(2'd0, 8'h09); repeat (20) @(negedge clk);
    on = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (active()) on++; end
    check("R10 long pulse clipped keeps strobe on", on, 20);
    wr(2'd0, 8'h01); wr(2'd1, 8'h00); repeat (10) @(negedge clk);
    on = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (active()) on++; end
    check("R10 period 2 keeps strobe on", on, 20);
  endtask

  initial begin
    #(8 * 190000);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_default();
    t_modes();
    wr(2'd0, 8'h00);
    t_polarity();
    t_regs();
    t_large();
    t_midwrite();
    t_gating();
    t_clip();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule